// File: doc/BRIEF.md
# Supply Monitor Deglitch and Fault Aggregator

This block takes ten raw power-good comparator outputs. Each output is 1 while its supply or reference is in range and 0 when it is out of range. The block brings every signal into the clock domain through a short synchronizer. It then cleans each one with a deglitch filter, and merges all out-of-range conditions into one registered error line for a downstream safety controller. The filter length is one shared setting. It runs from a bypass setting up to a 14.4 us window: code 15 times 192 cycles at 200 MHz.

Software reaches the block through a small register port. Writes are single-cycle and reads are combinational. A per-channel enable register sets which channels may raise the error. A mask is split over two registers, a lower one for channels 0 to 4 and an upper one for channels 5 to 9, and it can hold back any channel's fault. A status register shows the filtered power-good state of each channel. A separate coarse-status register shows the four channels that are enabled from reset: C0, C1, C2 and C3.

Top module: `smon_top`

## Requirements
- R1: After reset the registers read as follows: enable = 0x000F (channels 0 to 3 enabled), low mask = 0x001F, high mask = 0x001F, filter select = 0, status = 0x03FF. The error output is 0.
- R2: Each raw input passes through a 2-flop synchronizer. A channel's filtered value takes the synchronized value only after that value has differed from the filtered value on L consecutive clocks. L is select×192, or 1 when select is 0.
- R3: If the synchronized value agrees with the filtered value again before L clocks have gone by, the count restarts from zero.
- R4: The error output is registered. It is 1 exactly one clock after some channel is enabled, unmasked and has a filtered value of 0. A filtered value of 1 (in range) never raises it.
- R5: Low mask is at address 1, with bits [4:0] for channels 0 to 4. High mask is at address 2, with bits [4:0] for channels 5 to 9. A mask bit of 1 stops that channel from reaching the error output.
- R6: Enable is at address 0, with bits [9:0] for channels 0 to 9. A disabled channel never raises the error, and its status bit reads 1.
- R7: Status is at address 4, with bits [9:0] equal to the filtered value OR NOT enable. It is read-only, and writes to it are ignored.
- R8: Filter select is at address 3, in bits [3:0]. It reads back the value written.
- R9: Coarse status is at address 5. Bits [3:0] hold the filtered values of channels 0 to 3 whatever the enable setting, and bits [15:4] read 0. It is read-only.
- R10: Addresses 6 and 7 read 0. Register bits above each field read 0.
- R11: With select = 15, a held fault shows on the error output 2895 clocks after the input changes. That is 2 synchronizer clocks, 2880 filter clocks, 1 error register clock and 12 more clocks of margin at the check, and it is never sooner than 2883 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter and register clock, 200 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pok_raw | input | 10 | Raw power-good inputs, 1 = in range |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| vmon_err | output | 1 | Registered aggregated out-of-range error |

## Verification
A behavioural model steps alongside the design on every clock and predicts both the error line and the register read data. The filter is tried with a held drop in bypass, with a drop held past the window at the smallest non-zero select, and with a drop broken by a one-clock recovery. These show the bypass latency, the full count, and that a restart is not mistaken for a continued count. Masking is tried through each half of the split mask and disabling through the enable register. These show which gate holds a fault back, and that the coarse status still shows a disabled channel's fault. A full-ceiling window at select 15 is sampled just before and after its deadline.

// File: rtl/smon_pkg.sv
package smon_pkg;
  localparam int NCH      = 10;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = 4;
  localparam int LO_N     = NCH / 2;
  localparam int HI_N     = NCH - LO_N;
  localparam int COARSE_N = 4;

  localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASKLO = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASKHI = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_FSEL   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_COARSE = 3'd5;

  typedef logic [NCH-1:0] ch_vec_t;
endpackage

// File: rtl/smon_rst_sync.sv
module smon_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/smon_deglitch.sv
module smon_deglitch #(
  parameter int STEP        = 192,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             filt_o
);
  localparam int MAX_LEN = ((1 << SEL_W) - 1) * STEP;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   sync_s;
  logic                   filt_q, filt_d, filt_en;
  logic [CNT_W-1:0]       cnt_q, cnt_d, limit;
  logic                   cnt_en, mismatch, reached;
  logic [CNT_W:0]         cnt_inc;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
  end
  assign sync_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (sel_i == '0) limit = CNT_W'(1);
    else             limit = CNT_W'(sel_i) * CNT_W'(STEP);
  end

  assign mismatch = (sync_s != filt_q);
  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign reached  = (cnt_inc >= {1'b0, limit});

  always_comb begin
    filt_d  = filt_q;
    filt_en = 1'b0;
    cnt_d   = '0;
    cnt_en  = mismatch | (cnt_q != '0);
    if (mismatch) begin
      if (reached) begin
        filt_d  = sync_s;
        filt_en = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      if (filt_en) filt_q <= filt_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign filt_o = filt_q;

  // R2: a new filtered value is always the value seen at the synchronizer
  a_r2_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(sync_s)));

  // R3: agreement between synchronized input and output leaves the output alone
  a_r3_hold_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_s == filt_q) |=> $stable(filt_q));

  // R3: the count never reaches the ceiling window
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_LEN));
endmodule

// File: rtl/smon_regs.sv
module smon_regs
  import smon_pkg::*;
#(
  parameter ch_vec_t COARSE_SET = 10'h00F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ch_vec_t           filt_i,
  output logic [DATA_W-1:0] rdata_o,
  output ch_vec_t           en_o,
  output ch_vec_t           mask_o,
  output logic [SEL_W-1:0]  sel_o
);
  ch_vec_t          en_q, en_d;
  logic [LO_N-1:0]  mlo_q, mlo_d;
  logic [HI_N-1:0]  mhi_q, mhi_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             en_we, mlo_we, mhi_we, sel_we;
  ch_vec_t          status;

  assign en_we  = wr_i && (addr_i == ADR_ENABLE);
  assign mlo_we = wr_i && (addr_i == ADR_MASKLO);
  assign mhi_we = wr_i && (addr_i == ADR_MASKHI);
  assign sel_we = wr_i && (addr_i == ADR_FSEL);

  always_comb begin
    en_d  = wdata_i[NCH-1:0];
    mlo_d = wdata_i[LO_N-1:0];
    mhi_d = wdata_i[HI_N-1:0];
    sel_d = wdata_i[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= COARSE_SET;
      mlo_q <= '1;
      mhi_q <= '1;
      sel_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (mlo_we) mlo_q <= mlo_d;
      if (mhi_we) mhi_q <= mhi_d;
      if (sel_we) sel_q <= sel_d;
    end
  end

  assign status = filt_i | ~en_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_ENABLE: rdata_o[NCH-1:0]      = en_q;
      ADR_MASKLO: rdata_o[LO_N-1:0]     = mlo_q;
      ADR_MASKHI: rdata_o[HI_N-1:0]     = mhi_q;
      ADR_FSEL:   rdata_o[SEL_W-1:0]    = sel_q;
      ADR_STATUS: rdata_o[NCH-1:0]      = status;
      ADR_COARSE: rdata_o[COARSE_N-1:0] = filt_i[COARSE_N-1:0];
      default:    rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign mask_o = {mhi_q, mlo_q};
  assign sel_o  = sel_q;

  // R6: a disabled channel reads as in range
  a_r6_disabled_reads_good: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADR_STATUS) |-> ((rdata_o[NCH-1:0] | en_q) == '1));
endmodule

// File: rtl/smon_aggregate.sv
module smon_aggregate
  import smon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_vec_t en_i,
  input  ch_vec_t mask_i,
  input  ch_vec_t filt_i,
  output logic    err_o
);
  ch_vec_t fault;
  logic    err_q, err_d;

  always_comb begin
    fault = en_i & ~mask_i & ~filt_i;
    err_d = |fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  // R4: all channels in range on the previous clock means no error now
  a_r4_in_range_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&filt_i) |-> !err_q);

  // R5: a fully masked set of channels never raises the error
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(&mask_i) |-> !err_q);

  // R6: with every channel disabled the error stays low
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) == '0) |-> !err_q);
endmodule

// File: rtl/smon_top.sv
module smon_top
  import smon_pkg::*;
#(
  parameter int      STEP_CYCLES = 192,
  parameter int      SYNC_STAGES = 2,
  parameter ch_vec_t COARSE_SET  = 10'h00F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pok_raw,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              vmon_err
);
  logic             rst_int_n;
  ch_vec_t          filt, en, mask;
  logic [SEL_W-1:0] sel;

  smon_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smon_deglitch #(
      .STEP(STEP_CYCLES), .SYNC_STAGES(SYNC_STAGES), .SEL_W(SEL_W)
    ) u_flt (
      .clk(clk), .rst_n(rst_int_n), .raw_i(pok_raw[c]),
      .sel_i(sel), .filt_o(filt[c])
    );
  end

  smon_regs #(.COARSE_SET(COARSE_SET)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .filt_i(filt), .rdata_o(reg_rdata),
    .en_o(en), .mask_o(mask), .sel_o(sel)
  );

  smon_aggregate u_agg (
    .clk(clk), .rst_n(rst_int_n), .en_i(en), .mask_i(mask),
    .filt_i(filt), .err_o(vmon_err)
  );

  // R4: an error is only reported while some enabled channel is unmasked
  a_r4_needs_open_channel: assert property (@(posedge clk) disable iff (!rst_int_n)
    vmon_err |-> ($past(en & ~mask) != '0));
endmodule

// File: tb/sim_smon_top.sv
module sim_smon_top;
  import smon_pkg::*;
  localparam int STEP = 192;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    pok_raw = '1;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              vmon_err;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smon_top #(.STEP_CYCLES(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .pok_raw(pok_raw), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vmon_err(vmon_err)
  );

  // behavioural reference model
  int m_rcnt;
  bit [NCH-1:0] m_en, m_mask, m_filt, m_s1, m_s2;
  int m_sel;
  int m_cnt [NCH];
  bit m_err;

  function automatic logic [DATA_W-1:0] m_read(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v = '0;
    case (a)
      3'd0: v[9:0] = m_en;
      3'd1: v[4:0] = m_mask[4:0];
      3'd2: v[4:0] = m_mask[9:5];
      3'd3: v[3:0] = 4'(m_sel);
      3'd4: v[9:0] = m_filt | ~m_en;
      3'd5: v[3:0] = m_filt[3:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [ADDR_W-1:0] a);
    case (a)
      3'd0: return "R6";
      3'd1, 3'd2: return "R5";
      3'd3: return "R8";
      3'd4: return "R7";
      3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_en = 10'h00F; m_mask = '1; m_sel = 0; m_filt = '1;
    m_s1 = '1; m_s2 = '1; m_err = 1'b0;
    for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
  endtask

  always @(posedge clk) begin
    bit [NCH-1:0] f_old;
    int lim;
    if (!rst_n) begin
      m_rcnt = 0; model_reset();
    end else if (m_rcnt < 2) begin
      m_rcnt++; model_reset();
    end else begin
      f_old = m_filt;
      lim = (m_sel == 0) ? 1 : m_sel * STEP;
      m_err = |(m_en & ~m_mask & ~f_old);
      for (int c = 0; c < NCH; c++) begin
        if (m_s2[c] != f_old[c]) begin
          if (m_cnt[c] + 1 >= lim) begin m_filt[c] = m_s2[c]; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end else m_cnt[c] = 0;
      end
      m_s2 = m_s1; m_s1 = pok_raw;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_en = reg_wdata[9:0];
          3'd1: m_mask[4:0] = reg_wdata[4:0];
          3'd2: m_mask[9:5] = reg_wdata[4:0];
          3'd3: m_sel = int'(reg_wdata[3:0]);
          default: ;
        endcase
      end
    end
    #1;
    if (cmp_on && !done) begin
      checks++;
      if (vmon_err !== m_err) begin
        errors++;
        $display("FAIL R4 lockstep error output actual %0b expected %0b", vmon_err, m_err);
      end
      checks++;
      if (reg_rdata !== m_read(reg_addr)) begin
        errors++;
        $display("FAIL %s lockstep read addr %0d actual %h expected %h",
                 tag_of(reg_addr), reg_addr, reg_rdata, m_read(reg_addr));
      end
    end
  end

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic set_raw(input logic [NCH-1:0] v);
    @(negedge clk);
    pok_raw = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    cmp_on = 1'b1;
    // R1 reset state
    rd_check("R1 enable", 3'd0, 16'h000F);
    rd_check("R1 mask lo", 3'd1, 16'h001F);
    rd_check("R1 mask hi", 3'd2, 16'h001F);
    rd_check("R1 select", 3'd3, 16'h0000);
    rd_check("R1 status", 3'd4, 16'h03FF);
    check("R1 error", {15'b0, vmon_err}, 16'h0);
    rd_check("R10 addr6", 3'd6, 16'h0000);
    rd_check("R10 addr7", 3'd7, 16'h0000);
    // R10 / R8 field widths
    wr(3'd3, 16'hFFF3);
    rd_check("R8 select readback", 3'd3, 16'h0003);
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'hFFFF);
    rd_check("R10 enable width", 3'd0, 16'h03FF);
    // R2 bypass
    set_raw(10'h3EF);
    wait_clk(5);
    check("R2 bypass error", {15'b0, vmon_err}, 16'h1);
    rd_check("R7 status drop", 3'd4, 16'h03EF);
    set_raw('1);
    wait_clk(5);
    check("R4 recover", {15'b0, vmon_err}, 16'h0);
    // R2 / R3 window of 192
    wr(3'd3, 16'h0001);
    set_raw(10'h37F);
    wait_clk(100);
    check("R2 inside window", {15'b0, vmon_err}, 16'h0);
    set_raw('1);
    set_raw(10'h37F);
    wait_clk(150);
    check("R3 restart", {15'b0, vmon_err}, 16'h0);
    wait_clk(60);
    check("R2 window done", {15'b0, vmon_err}, 16'h1);
    // R5 split mask
    wr(3'd3, 16'h0000);
    wr(3'd2, 16'h0004);
    wait_clk(3);
    check("R5 high mask blocks", {15'b0, vmon_err}, 16'h0);
    rd_check("R7 masked status", 3'd4, 16'h037F);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0004);
    wait_clk(3);
    check("R5 low mask no effect on ch7", {15'b0, vmon_err}, 16'h1);
    // R6 disable
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h037F);
    wait_clk(3);
    check("R6 disabled quiet", {15'b0, vmon_err}, 16'h0);
    rd_check("R6 disabled status", 3'd4, 16'h03FF);
    // R9 coarse with disabled channel
    wr(3'd0, 16'h037D);
    set_raw(10'h37D);
    wait_clk(6);
    rd_check("R9 coarse", 3'd5, 16'h000D);
    rd_check("R7 status ch1 disabled", 3'd4, 16'h03FF);
    check("R6 ch1 disabled quiet", {15'b0, vmon_err}, 16'h0);
    // R7 read-only
    wr(3'd4, 16'h0000);
    rd_check("R7 write ignored", 3'd4, 16'h03FF);
    wr(3'd5, 16'h0000);
    rd_check("R9 write ignored", 3'd5, 16'h000D);
    set_raw('1);
    wr(3'd0, 16'h03FF);
    wait_clk(6);
    check("R4 all good", {15'b0, vmon_err}, 16'h0);
    // R11 ceiling window
    wr(3'd3, 16'h000F);
    @(negedge clk);
    pok_raw = 10'h3FE;
    wait_clk(15 * STEP + 2);
    check("R11 before ceiling", {15'b0, vmon_err}, 16'h0);
    wait_clk(12);
    check("R11 after ceiling", {15'b0, vmon_err}, 16'h1);
    rd_check("R9 coarse ch0", 3'd5, 16'h000E);
    set_raw('1);
    wait_clk(15 * STEP + 10);
    check("R2 recovery at ceiling", {15'b0, vmon_err}, 16'h0);
    finish_run();
  end
endmodule